// File: doc/BRIEF.md
# Pulse-Counting Signed Decimal Accumulator

This block is a signed decimal register of `NDIG` digit counters and a sign flag. It adds by counting pulse trains instead of taking parallel words. Time is split into add times by phase strobes from outside the block. Each add time has nine digit-pulse slots, one extra slot, one carry slot and one end slot. A sending unit puts pulses on one line per digit and on one sign line. The accumulator counts the pulses on the input that the active program selects. A digit that wraps past nine sets a carry flip-flop. All the saved carries resolve in the carry slot, and a carry that reaches a digit already at nine ripples on in that same slot.

Each of the `NPROG` programs has an operation code, a clear setting and, from index `RPT_BASE` upward, a repeat count. A start pulse arms a program, and it runs from the next add-time boundary. When the last add time ends, a one-cycle completion pulse goes out on that program's line. A negative value is kept as the ten's complement of its magnitude with the sign flag set. When the accumulator transmits, it sends either its direct value or the ten's complement of that value.

Top module: `dacc_accum`

## Requirements
- R1: After reset the value is zero with the sign clear, and all pulse outputs and completion lines are low.
- R2: Operation codes: 0 to NIN-1 receive on that input, NIN is a no-op, NIN+1 sends direct, NIN+2 sends both forms, NIN+3 sends complement (default: 0-4, 5, 6, 7, 8). Digit lines are bits 0..NDIG-1 with the units digit at bit 0, and the sign line is bit NDIG. When sending direct, a digit of value d pulses in digit slots 0..d-1, and the sign line pulses in the extra slot only when the sign is set.
- R3: When sending the complement, a digit d pulses in digit slots d..8 (9-d pulses), the units line pulses once more in the extra slot, and the sign line pulses in the extra slot only when the sign is clear.
- R4: When receiving, each pulse on a selected digit line advances that digit by one, and each pulse on the selected sign line toggles the sign. Wraps past nine are held and resolved in the carry slot, rippling through nines. A carry out of the top digit toggles the sign, so the value adds modulo 2*10^NDIG.
- R5: Pulses on inputs that the active program does not select leave the value unchanged.
- R6: A start pulse is accepted only while no program is armed or running. Among simultaneous start pulses the lowest index wins. The program begins at the next end slot, and start pulses that arrive while busy are dropped.
- R7: A program with index >= RPT_BASE (default 4) runs for as many add times as its repeat field, with 0 counted as 1. Programs below RPT_BASE run for one add time whatever their field holds.
- R8: In the cycle after the end slot of a program's last add time, exactly that program's completion line is high, for one cycle.
- R9: A program whose clear setting is 1 leaves the value zero with the sign clear after its last add time.
- R10: The send-both operation produces both pulse trains in the same add time.
- R11: A no-op program emits no pulses, leaves the value unchanged, and still signals completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_dig | input | 1 | Digit-pulse slot strobe (nine per add time) |
| ph_one | input | 1 | Extra slot strobe (sign and complement units pulse) |
| ph_carry | input | 1 | Carry slot strobe |
| ph_end | input | 1 | End-of-add-time strobe |
| prog_go | input | NPROG (12) | Program start pulses, one per program |
| cfg_op | input | NPROG*OP_W (48) | Operation code per program, program p at bits p*OP_W |
| cfg_rpt | input | NPROG*RPT_W (48) | Repeat count per program |
| cfg_clr | input | NPROG (12) | Clear setting per program |
| rx_pulse | input | NIN*(NDIG+1) (55) | Receive pulse lines, input k at bits k*(NDIG+1) |
| a_pulse | output | NDIG+1 (11) | Direct transmit pulse lines |
| s_pulse | output | NDIG+1 (11) | Complement transmit pulse lines |
| done | output | NPROG (12) | Completion pulses, one per program |

## Verification
The bench builds the block with its default parameters: ten digits, five inputs, twelve programs and repeat counts from program 4 upward. With ten digits the sum 42 + 9999999958 carries from the units digit through all nine higher digits into the sign. The bench can therefore check the longest ripple and the sign toggle, as well as negative values and zero crossings. Twelve programs leave room for repeated, clearing, no-op and priority programs at the same time, including a repeat field that a low-index program must ignore.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2
   } dacc_state_e;

   localparam int DIG_W = 4;
endpackage

// File: rtl/dacc_digit.sv
module dacc_digit
   import dacc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             pulse,
   input  logic             carry_ph,
   input  logic             cin,
   output logic [DIG_W-1:0] val,
   output logic             cout
);
   localparam logic [DIG_W-1:0] NINE = DIG_W'(9);

   logic [DIG_W-1:0] v_q;
   logic             cf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q  <= '0;
         cf_q <= 1'b0;
      end else if (clr) begin
         v_q  <= '0;
         cf_q <= 1'b0;
      end else if (carry_ph) begin
         if (cin) v_q <= (v_q == NINE) ? '0 : v_q + DIG_W'(1);
         cf_q <= 1'b0;
      end else if (pulse) begin
         if (v_q == NINE) begin
            v_q  <= '0;
            cf_q <= 1'b1;
         end else begin
            v_q <= v_q + DIG_W'(1);
         end
      end
   end

   assign val  = v_q;
   assign cout = carry_ph & (cf_q | (cin & (v_q == NINE)));

   // R4
   digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n) val <= NINE);
   // R4
   carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) carry_ph |=> !cf_q);
endmodule

// File: rtl/dacc_xmit.sv
module dacc_xmit
   import dacc_pkg::*;
#(
   parameter int NDIG = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ph_dig,
   input  logic                  ph_one,
   input  logic                  ph_end,
   input  logic                  en_a,
   input  logic                  en_s,
   input  logic [NDIG*DIG_W-1:0] dig,
   input  logic                  neg,
   output logic [NDIG:0]         a_pulse,
   output logic [NDIG:0]         s_pulse
);
   logic [DIG_W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot_q <= '0;
      else if (ph_end) slot_q <= '0;
      else if (ph_dig) slot_q <= slot_q + DIG_W'(1);
   end

   for (genvar i = 0; i < NDIG; i++) begin : g_line
      logic early;
      assign early      = slot_q < dig[i*DIG_W +: DIG_W];
      assign a_pulse[i] = en_a & ph_dig & early;
      if (i == 0) begin : g_units
         assign s_pulse[i] = en_s & ((ph_dig & ~early) | ph_one);
      end else begin : g_upper
         assign s_pulse[i] = en_s & ph_dig & ~early;
      end
   end

   assign a_pulse[NDIG] = en_a & ph_one & neg;
   assign s_pulse[NDIG] = en_s & ph_one & ~neg;

   // R2
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ph_dig || ph_one) |-> (a_pulse == '0) && (s_pulse == '0));
   // R10
   a_s_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_dig |-> ((a_pulse[NDIG-1:0] & s_pulse[NDIG-1:0]) == '0));
endmodule

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
   import dacc_pkg::*;
#(
   parameter int NPROG    = 12,
   parameter int OP_W     = 4,
   parameter int RPT_W    = 4,
   parameter int RPT_BASE = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ph_end,
   input  logic [NPROG-1:0]       prog_go,
   input  logic [NPROG*OP_W-1:0]  cfg_op,
   input  logic [NPROG*RPT_W-1:0] cfg_rpt,
   input  logic [NPROG-1:0]       cfg_clr,
   output logic                   run,
   output logic [OP_W-1:0]        op,
   output logic                   clr_now,
   output logic [NPROG-1:0]       done
);
   localparam int SEL_W = (NPROG > 1) ? $clog2(NPROG) : 1;

   dacc_state_e      st_q;
   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] pick;
   logic [RPT_W-1:0] rem_q;
   logic [NPROG-1:0] done_q;
   logic [RPT_W-1:0] rpt_eff [NPROG];
   logic             last;

   for (genvar p = 0; p < NPROG; p++) begin : g_rpt
      if (p < RPT_BASE) begin : g_single
         assign rpt_eff[p] = RPT_W'(1);
      end else begin : g_counted
         assign rpt_eff[p] = (cfg_rpt[p*RPT_W +: RPT_W] == '0) ? RPT_W'(1)
                                                             : cfg_rpt[p*RPT_W +: RPT_W];
      end
   end

   always_comb begin
      pick = '0;
      for (int p = NPROG - 1; p >= 0; p--) begin
         if (prog_go[p]) pick = SEL_W'(p);
      end
   end

   assign run     = (st_q == ST_RUN);
   assign op      = cfg_op[sel_q*OP_W +: OP_W];
   assign last    = run & ph_end & (rem_q == RPT_W'(1));
   assign clr_now = last & cfg_clr[sel_q];
   assign done    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sel_q  <= '0;
         rem_q  <= '0;
         done_q <= '0;
      end else begin
         done_q <= '0;
         case (st_q)
            ST_IDLE: if (|prog_go) begin
               st_q  <= ST_ARMED;
               sel_q <= pick;
            end
            ST_ARMED: if (ph_end) begin
               st_q  <= ST_RUN;
               rem_q <= rpt_eff[sel_q];
            end
            ST_RUN: if (ph_end) begin
               if (rem_q == RPT_W'(1)) begin
                  st_q          <= ST_IDLE;
                  done_q[sel_q] <= 1'b1;
               end else begin
                  rem_q <= rem_q - RPT_W'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R8
   done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(done));
   // R8
   done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |-> $past(run && ph_end));
   // R6
   sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> $stable(sel_q));
endmodule

// File: rtl/dacc_accum.sv
module dacc_accum
   import dacc_pkg::*;
#(
   parameter int NDIG     = 10,
   parameter int NIN      = 5,
   parameter int NPROG    = 12,
   parameter int RPT_W    = 4,
   parameter int RPT_BASE = 4,
   localparam int OP_W    = $clog2(NIN + 4),
   localparam int LW      = NDIG + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ph_dig,
   input  logic                   ph_one,
   input  logic                   ph_carry,
   input  logic                   ph_end,
   input  logic [NPROG-1:0]       prog_go,
   input  logic [NPROG*OP_W-1:0]  cfg_op,
   input  logic [NPROG*RPT_W-1:0] cfg_rpt,
   input  logic [NPROG-1:0]       cfg_clr,
   input  logic [NIN*LW-1:0]      rx_pulse,
   output logic [LW-1:0]          a_pulse,
   output logic [LW-1:0]          s_pulse,
   output logic [NPROG-1:0]       done
);
   localparam logic [OP_W-1:0] OPC_A  = OP_W'(NIN + 1);
   localparam logic [OP_W-1:0] OPC_AS = OP_W'(NIN + 2);
   localparam logic [OP_W-1:0] OPC_S  = OP_W'(NIN + 3);

   if (NDIG < 2 || NDIG > 18) begin : g_bad_ndig
      $error("dacc_accum: NDIG out of range");
   end
   if (NIN < 1) begin : g_bad_nin
      $error("dacc_accum: NIN must be at least 1");
   end
   if (RPT_BASE > NPROG || RPT_W < 1) begin : g_bad_rpt
      $error("dacc_accum: repeat settings out of range");
   end

   logic                  run;
   logic [OP_W-1:0]       op;
   logic                  clr_now;
   logic                  rx_en;
   logic [LW-1:0]         rx_line;
   logic                  cnt;
   logic [NDIG:0]         cy;
   logic [NDIG*DIG_W-1:0] dig;
   logic                  neg_q;
   logic                  en_a;
   logic                  en_s;

   dacc_ctrl #(
      .NPROG(NPROG), .OP_W(OP_W), .RPT_W(RPT_W), .RPT_BASE(RPT_BASE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ph_end(ph_end), .prog_go(prog_go),
      .cfg_op(cfg_op), .cfg_rpt(cfg_rpt), .cfg_clr(cfg_clr),
      .run(run), .op(op), .clr_now(clr_now), .done(done)
   );

   always_comb begin
      rx_en   = 1'b0;
      rx_line = '0;
      for (int k = 0; k < NIN; k++) begin
         if (run && op == OP_W'(k)) begin
            rx_en   = 1'b1;
            rx_line = rx_pulse[k*LW +: LW];
         end
      end
   end

   assign cnt   = rx_en & (ph_dig | ph_one);
   assign cy[0] = 1'b0;

   for (genvar i = 0; i < NDIG; i++) begin : g_dig
      dacc_digit u_digit (
         .clk(clk), .rst_n(rst_n), .clr(clr_now),
         .pulse(cnt & rx_line[i]), .carry_ph(ph_carry & rx_en),
         .cin(cy[i]), .val(dig[i*DIG_W +: DIG_W]), .cout(cy[i+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                neg_q <= 1'b0;
      else if (clr_now)                          neg_q <= 1'b0;
      else if ((cnt & rx_line[NDIG]) ^ cy[NDIG]) neg_q <= ~neg_q;
   end

   assign en_a = run & (op == OPC_A || op == OPC_AS);
   assign en_s = run & (op == OPC_S || op == OPC_AS);

   dacc_xmit #(.NDIG(NDIG)) u_xmit (
      .clk(clk), .rst_n(rst_n), .ph_dig(ph_dig), .ph_one(ph_one), .ph_end(ph_end),
      .en_a(en_a), .en_s(en_s), .dig(dig), .neg(neg_q),
      .a_pulse(a_pulse), .s_pulse(s_pulse)
   );

   // R5
   dig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !clr_now) |=> $stable(dig));
   // R4
   sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !clr_now) |=> $stable(neg_q));
endmodule

// File: tb/dacc_accum_test.sv
module dacc_accum_test;
   localparam int NDIG  = 10;
   localparam int NIN   = 5;
   localparam int NPROG = 12;
   localparam int RPT_W = 4;
   localparam int OP_W  = $clog2(NIN + 4);
   localparam int LW    = NDIG + 1;
   localparam longint TEN10 = 64'd10000000000;
   localparam longint MODV  = 64'd20000000000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ph_dig = 0, ph_one = 0, ph_carry = 0, ph_end = 0;
   logic [NPROG-1:0]       prog_go = '0;
   logic [NPROG*OP_W-1:0]  cfg_op  = '0;
   logic [NPROG*RPT_W-1:0] cfg_rpt = '0;
   logic [NPROG-1:0]       cfg_clr = '0;
   logic [NIN*LW-1:0]      rx_pulse = '0;
   logic [LW-1:0]          a_pulse, s_pulse;
   logic [NPROG-1:0]       done;

   always #10 clk = ~clk;

   dacc_accum uut (
      .clk(clk), .rst_n(rst_n), .ph_dig(ph_dig), .ph_one(ph_one),
      .ph_carry(ph_carry), .ph_end(ph_end), .prog_go(prog_go),
      .cfg_op(cfg_op), .cfg_rpt(cfg_rpt), .cfg_clr(cfg_clr),
      .rx_pulse(rx_pulse), .a_pulse(a_pulse), .s_pulse(s_pulse), .done(done)
   );

   int nchk = 0, nfail = 0, seq = 0, tx_port = -1;
   longint tx_val = 0;
   logic [NPROG-1:0] go_req = '0, done_seen = '0;
   int cnt_a [LW];
   int cnt_s [LW];
   // behavioural reference
   int m_st = 0, m_sel = 0, m_rem = 0;
   longint m_val = 0, m_acc = 0;
   logic [NPROG-1:0] m_done = '0;

   function automatic longint pw10(int n);
      longint r = 1;
      for (int i = 0; i < n; i++) r = r * 10;
      return r;
   endfunction

   function automatic int dig_of(longint v, int i);
      return int'((v / pw10(i)) % 10);
   endfunction

   function automatic int op_of(int p);
      return int'(cfg_op[p*OP_W +: OP_W]);
   endfunction

   function automatic int rpt_of(int p);
      int f = int'(cfg_rpt[p*RPT_W +: RPT_W]);
      if (p < 4 || f == 0) return 1;
      return f;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_prog(int p, int opc, int rpt, bit clr);
      cfg_op[p*OP_W +: OP_W]    = OP_W'(opc);
      cfg_rpt[p*RPT_W +: RPT_W] = RPT_W'(rpt);
      cfg_clr[p]                = clr;
   endtask

   task automatic cycle();
      logic [LW-1:0] ea, es;
      int opc;
      logic [NPROG-1:0] dn;
      @(negedge clk);
      ph_dig = (seq < 9); ph_one = (seq == 9); ph_carry = (seq == 10); ph_end = (seq == 11);
      prog_go = go_req; go_req = '0;
      rx_pulse = '0;
      if (tx_port >= 0) begin
         for (int i = 0; i < NDIG; i++)
            if (seq < 9 && seq < dig_of(tx_val, i)) rx_pulse[tx_port*LW + i] = 1'b1;
         if (seq == 9 && tx_val >= TEN10) rx_pulse[tx_port*LW + NDIG] = 1'b1;
      end
      #2;
      ea = '0; es = '0;
      opc = op_of(m_sel);
      if (m_st == 2) begin
         for (int i = 0; i < NDIG; i++) begin
            if ((opc == 6 || opc == 7) && seq < 9 && seq < dig_of(m_val, i)) ea[i] = 1'b1;
            if ((opc == 8 || opc == 7) && seq < 9 && seq >= dig_of(m_val, i)) es[i] = 1'b1;
         end
         if ((opc == 6 || opc == 7) && seq == 9 && m_val >= TEN10) ea[NDIG] = 1'b1;
         if ((opc == 8 || opc == 7) && seq == 9) begin
            es[0] = 1'b1;
            if (m_val < TEN10) es[NDIG] = 1'b1;
         end
      end
      chk(a_pulse == ea, "R2 direct train", longint'(a_pulse), longint'(ea));
      chk(s_pulse == es, "R3 complement train", longint'(s_pulse), longint'(es));
      chk(done == m_done, "R8 completion", longint'(done), longint'(m_done));
      for (int i = 0; i < LW; i++) begin
         cnt_a[i] += int'(a_pulse[i]);
         cnt_s[i] += int'(s_pulse[i]);
      end
      done_seen |= done;
      // reference update for the coming edge
      dn = '0;
      if (m_st == 0) begin
         if (prog_go != '0) begin
            for (int p = NPROG - 1; p >= 0; p--) if (prog_go[p]) m_sel = p;
            m_st = 1;
         end
      end else if (m_st == 1) begin
         if (seq == 11) begin m_st = 2; m_rem = rpt_of(m_sel); end
      end else begin
         if (opc < NIN && seq <= 9)
            for (int i = 0; i < LW; i++)
               if (rx_pulse[opc*LW + i]) m_acc += pw10(i);
         if (seq == 10) begin m_val = (m_val + m_acc) % MODV; m_acc = 0; end
         if (seq == 11) begin
            if (m_rem == 1) begin
               m_st = 0; dn[m_sel] = 1'b1;
               if (cfg_clr[m_sel]) m_val = 0;
            end else m_rem--;
         end
      end
      m_done = dn;
      seq = (seq == 11) ? 0 : seq + 1;
   endtask

   task automatic clear_counts();
      for (int i = 0; i < LW; i++) begin cnt_a[i] = 0; cnt_s[i] = 0; end
      done_seen = '0;
   endtask

   task automatic run_prog(int p, logic [NPROG-1:0] go, string req);
      clear_counts();
      go_req = go;
      for (int n = 0; n < 200; n++) begin
         cycle();
         if (done_seen[p]) break;
      end
      chk(done_seen[p], req, longint'(done_seen), longint'(1) << p);
   endtask

   function automatic longint sum_a();
      longint r = 0;
      for (int i = 0; i < LW; i++) r += longint'(cnt_a[i]) * pw10(i);
      return r;
   endfunction

   function automatic longint sum_s();
      longint r = 0;
      for (int i = 0; i < LW; i++) r += longint'(cnt_s[i]) * pw10(i);
      return r;
   endfunction

   task automatic read_check(longint exp, string req);
      run_prog(0, 12'b1 << 0, req);
      chk(sum_a() == exp, req, sum_a(), exp);
   endtask

   task automatic add_via(int p, int port, longint v, string req);
      tx_port = port; tx_val = v;
      run_prog(p, 12'b1 << p, req);
      tx_port = -1;
   endtask

   initial begin
      #(20 * 180000);
      nfail++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      set_prog(0, 6, 0, 0);   // direct send
      set_prog(1, 8, 0, 0);   // complement send
      set_prog(2, 0, 5, 0);   // receive input 0, repeat field ignored (R7)
      set_prog(3, 1, 0, 0);   // receive input 1
      set_prog(4, 7, 1, 0);   // send both
      set_prog(5, 0, 3, 0);   // receive input 0, three add times
      set_prog(6, 5, 1, 0);   // no-op
      set_prog(7, 6, 1, 1);   // direct send then clear
      set_prog(8, 5, 1, 0);
      set_prog(9, 5, 1, 0);
      set_prog(10, 5, 1, 0);
      set_prog(11, 4, 0, 0);  // receive input 4, repeat 0 counts as 1
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state at the ports
      chk(a_pulse == '0 && s_pulse == '0, "R1 reset pulses", longint'(a_pulse | s_pulse), 0);
      chk(done == '0, "R1 reset done", longint'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      read_check(0, "R1 reset value");
      // R4 basic adds with deferred carry
      add_via(2, 0, 15, "R4 add 15");
      read_check(15, "R4 value 15");
      add_via(2, 0, 27, "R4 add 27");
      read_check(42, "R4 carry gives 42");
      add_via(2, 0, 64'd9999999958, "R4 long ripple");
      read_check(TEN10, "R4 ripple into sign");
      add_via(2, 0, TEN10, "R4 sign line");
      read_check(0, "R4 sign line toggle");
      // R5 other inputs ignored
      add_via(2, 1, 123, "R5 unselected");
      read_check(0, "R5 unselected input");
      add_via(3, 1, 123, "R4 add on input 1");
      read_check(123, "R4 value 123");
      // R3 complement send
      run_prog(1, 12'b1 << 1, "R3 complement run");
      chk(sum_s() == MODV - 123, "R3 complement value", sum_s(), MODV - 123);
      chk(sum_a() == 0, "R3 no direct pulses", sum_a(), 0);
      // R10 both forms
      run_prog(4, 12'b1 << 4, "R10 both run");
      chk(sum_a() == 123, "R10 direct part", sum_a(), 123);
      chk(sum_s() == MODV - 123, "R10 complement part", sum_s(), MODV - 123);
      // R7 repeat count
      add_via(5, 0, 7, "R7 repeat run");
      read_check(144, "R7 three add times");
      // R4 / R2 negative result with sign pulse
      add_via(2, 0, MODV - 200, "R4 subtract");
      read_check(MODV - 56, "R2 negative value with sign");
      // R11 no-op
      run_prog(6, 12'b1 << 6, "R11 no-op done");
      chk(sum_a() == 0 && sum_s() == 0, "R11 no pulses", sum_a() + sum_s(), 0);
      read_check(MODV - 56, "R11 value kept");
      // R9 clear after send
      run_prog(7, 12'b1 << 7, "R9 clear run");
      chk(sum_a() == MODV - 56, "R9 value sent before clear", sum_a(), MODV - 56);
      read_check(0, "R9 cleared");
      // R6 lowest index wins
      tx_port = 0; tx_val = 5;
      run_prog(2, (12'b1 << 3) | (12'b1 << 2), "R6 priority winner");
      chk(done_seen[3] == 1'b0, "R6 loser silent", longint'(done_seen), 12'b1 << 2);
      tx_port = -1;
      read_check(5, "R6 winner value, R7 low program single");
      // R6 start while busy dropped
      clear_counts();
      tx_port = 0; tx_val = 5;
      go_req = 12'b1 << 5;
      repeat (15) cycle();
      go_req = 12'b1 << 3;
      for (int n = 0; n < 100; n++) begin
         cycle();
         if (done_seen[5]) break;
      end
      tx_port = -1;
      repeat (30) cycle();
      chk(done_seen == (12'b1 << 5), "R6 busy start dropped", longint'(done_seen), 12'b1 << 5);
      read_check(20, "R6 busy value");
      // R7 zero repeat field
      add_via(11, 4, 1, "R7 zero repeat run");
      read_check(21, "R7 zero repeat counts once");
      repeat (5) cycle();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule